// File: doc/BRIEF.md
# Programmable Memory and Peripheral Chip-Select Decoder

The decoder sits on the address side of a small embedded processor bus. It turns a 20-bit memory address, or a 16-bit I/O address, into active-low select lines. There are four kinds of select:

- one select for the top of memory;
- one select for the bottom of memory;
- four selects that share a movable midrange block;
- a group of peripheral selects. These sit at 256-byte spacing and can be placed in memory space or in I/O space.

For the region that wins, the decoder also presents its programmed wait-state count and ready requirement. An external sequencer uses these to stretch the bus cycle.

Software programs the block through five configuration words on a simple write port. The top-of-memory select is live at reset, so that the first fetches near the top of memory reach boot storage. Every other select stays off until it is enabled.

The peripheral and midrange selects follow the address phase of the multiplexed bus combinationally. The top and bottom selects come from a register and lag the address by one clock.

Top module: `csdec_top`

## Requirements
- R1: Out of reset the upper select is enabled with lower bound F0000h, 3 wait states and ready required. On a valid memory cycle `ucs_n` is low for F0000h and FFFFFh and high for EFFFFh.
- R2: Config word 0 sets the upper region. Bits [15:6] are the lower bound as address bits [19:10], bit 3 is enable, bit 2 is ready and bits [1:0] are the wait count. The region always ends at FFFFFh.
- R3: The lower select is disabled out of reset. Config word 1 uses the same layout as word 0. Its bits [15:6] give the last 1-Kbyte block, and the region runs from 00000h to the end of that block.
- R4: Config word 2 uses the same layout. Bits [15:11] place a 32-Kbyte midrange block, aligned to its size. Inside the block, address bits [14:13] pick which one of `mcs_n[3:0]` goes low.
- R5: Config word 3 bits [11:0] give the peripheral base as address bits [19:8]. Slot n, at base+n*256 for n in 0..6, drives `pcs_n[n]`. Slot 4 drives nothing, and `pcs_n[4]` stays high. The peripheral group is disabled out of reset.
- R6: Config word 4 controls the peripheral group. Bit 5 selects I/O space, bit 4 is enable, bit 3 is ready and bits [2:0] are the wait code. In I/O space the group answers only non-memory cycles, compares address bits [15:8] with base bits [7:0], and ignores address bits [19:16]. In memory space it answers only memory cycles.
- R7: `mcs_n`, `pcs_n`, `wait_st` and `need_rdy` follow the current address in the same cycle. `ucs_n` and `lcs_n` show the decode of the address presented in the previous cycle.
- R8: While `addr_vld` is low, `mcs_n` and `pcs_n` are all high, and `ucs_n` and `lcs_n` are high in the following cycle.
- R9: When regions overlap, priority is upper, then lower, then peripheral, then midrange. At most one select is low for any one address.
- R10: `wait_st` and `need_rdy` carry the winning region's settings, or 0 when no region wins. For peripheral slots 0..3 the wait codes 0..7 mean 0,1,2,3,5,7,9,15 states. Slots 5 and 6 use code bits [1:0] only.
- R11: A configuration write takes effect from the next cycle. A decode in the write cycle uses the old setting. Select values 5..7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 20 | Bus address |
| is_mem | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| addr_vld | input | 1 | Address phase strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 3 | Configuration word index |
| cfg_wdata | input | 16 | Configuration write data |
| ucs_n | output | 1 | Upper memory select, registered |
| lcs_n | output | 1 | Lower memory select, registered |
| mcs_n | output | 4 | Midrange selects |
| pcs_n | output | 7 | Peripheral selects; bit 4 unused, held high |
| wait_st | output | 4 | Wait states of the winning region |
| need_rdy | output | 1 | Winning region requires external ready |

## Verification
A configuration write and an address decode can land in the same cycle. The decode must still use the setting that was in force before the write. The bench forces this case with a directed write that disables the midrange block while an address inside that block is on the bus. It expects the midrange select in that cycle and no select in the next. Random runs then mix writes to all five words with decodes near each region's edges. A bench model updates its configuration only after it has computed the expected value for the cycle.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
  localparam int ADDR_W = 20;
  localparam int KB_W   = 10;   // address bits [19:10]
  localparam int PB_W   = 12;   // address bits [19:8]

  typedef struct packed {
    logic [KB_W-1:0] bound;
    logic            en;
    logic            rdy;
    logic [1:0]      ws;
  } mreg_t;

  typedef struct packed {
    logic [PB_W-1:0] base;
    logic            io;
    logic            en;
    logic            rdy;
    logic [2:0]      code;
  } preg_t;

  typedef enum logic [2:0] {WIN_NONE, WIN_U, WIN_L, WIN_P, WIN_M} win_e;

  function automatic logic [3:0] pcs_wait(input logic [2:0] code, input logic narrow);
    logic [3:0] w;
    if (narrow) w = {2'b00, code[1:0]};
    else begin
      case (code)
        3'd4:    w = 4'd5;
        3'd5:    w = 4'd7;
        3'd6:    w = 4'd9;
        3'd7:    w = 4'd15;
        default: w = {1'b0, code};
      endcase
    end
    return w;
  endfunction
endpackage

// File: rtl/csdec_regs.sv
module csdec_regs
  import csdec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [2:0]  sel,
  input  logic [15:0] wdata,
  output mreg_t       ucfg,
  output mreg_t       lcfg,
  output mreg_t       mcfg,
  output preg_t       pcfg
);
  localparam logic [KB_W-1:0] UCS_RST_BOUND = 10'h3C0;

  mreg_t u_d, l_d, m_d;
  preg_t p_d;
  logic [PB_W-1:0] pbase_d, pbase_q;
  mreg_t wr_m;

  always_comb begin
    wr_m = '{bound: wdata[15:6], en: wdata[3], rdy: wdata[2], ws: wdata[1:0]};
    u_d = ucfg;
    l_d = lcfg;
    m_d = mcfg;
    p_d = pcfg;
    pbase_d = pbase_q;
    if (we) begin
      case (sel)
        3'd0: u_d = wr_m;
        3'd1: l_d = wr_m;
        3'd2: m_d = wr_m;
        3'd3: pbase_d = wdata[PB_W-1:0];
        3'd4: begin
          p_d.io   = wdata[5];
          p_d.en   = wdata[4];
          p_d.rdy  = wdata[3];
          p_d.code = wdata[2:0];
        end
        default: ;
      endcase
    end
    p_d.base = pbase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ucfg    <= '{bound: UCS_RST_BOUND, en: 1'b1, rdy: 1'b1, ws: 2'd3};
      lcfg    <= '0;
      mcfg    <= '0;
      pcfg    <= '0;
      pbase_q <= '0;
    end else begin
      ucfg    <= u_d;
      lcfg    <= l_d;
      mcfg    <= m_d;
      pcfg    <= p_d;
      pbase_q <= pbase_d;
    end
  end
endmodule

// File: rtl/csdec_match.sv
module csdec_match
  import csdec_pkg::*;
#(
  parameter int MID_LOG2 = 15,
  parameter int NSLOT    = 7,
  parameter int GAP_SLOT = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_mem,
  input  mreg_t             ucfg,
  input  mreg_t             lcfg,
  input  mreg_t             mcfg,
  input  preg_t             pcfg,
  output logic              hit_u,
  output logic              hit_l,
  output logic              hit_m,
  output logic [1:0]        msub,
  output logic              hit_p,
  output logic [2:0]        pslot
);
  localparam int MTAG_W = ADDR_W - MID_LOG2;

  logic [PB_W-1:0] p_addr, p_base, p_off;
  logic            p_space;

  always_comb begin
    hit_u = is_mem && ucfg.en && (addr[ADDR_W-1:KB_W] >= ucfg.bound);
    hit_l = is_mem && lcfg.en && (addr[ADDR_W-1:KB_W] <= lcfg.bound);
    hit_m = is_mem && mcfg.en &&
            (addr[ADDR_W-1:MID_LOG2] == mcfg.bound[KB_W-1 -: MTAG_W]);
    msub  = addr[MID_LOG2-1 -: 2];

    if (pcfg.io) begin
      p_addr = {4'b0000, addr[15:8]};
      p_base = {4'b0000, pcfg.base[7:0]};
    end else begin
      p_addr = addr[ADDR_W-1:8];
      p_base = pcfg.base;
    end
    p_off   = p_addr - p_base;
    p_space = pcfg.io ? !is_mem : is_mem;
    hit_p   = pcfg.en && p_space && (p_off < PB_W'(NSLOT)) && (p_off != PB_W'(GAP_SLOT));
    pslot   = p_off[2:0];
  end
endmodule

// File: rtl/csdec_top.sv
module csdec_top
  import csdec_pkg::*;
#(
  parameter int MID_LOG2 = 15,
  parameter int NMCS     = 4,
  parameter int NPCS     = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [19:0] addr,
  input  logic        is_mem,
  input  logic        addr_vld,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [15:0] cfg_wdata,
  output logic        ucs_n,
  output logic        lcs_n,
  output logic [3:0]  mcs_n,
  output logic [6:0]  pcs_n,
  output logic [3:0]  wait_st,
  output logic        need_rdy
);
  localparam int GAP_SLOT = 4;

  logic [1:0] rst_sync;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  mreg_t ucfg, lcfg, mcfg;
  preg_t pcfg;

  csdec_regs u_regs (
    .clk(clk), .rst_n(rst_i), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .ucfg(ucfg), .lcfg(lcfg), .mcfg(mcfg), .pcfg(pcfg)
  );

  logic       hit_u, hit_l, hit_m, hit_p;
  logic [1:0] msub;
  logic [2:0] pslot;

  csdec_match #(.MID_LOG2(MID_LOG2), .NSLOT(NPCS), .GAP_SLOT(GAP_SLOT)) u_match (
    .addr(addr), .is_mem(is_mem), .ucfg(ucfg), .lcfg(lcfg), .mcfg(mcfg), .pcfg(pcfg),
    .hit_u(hit_u), .hit_l(hit_l), .hit_m(hit_m), .msub(msub), .hit_p(hit_p), .pslot(pslot)
  );

  win_e win;
  logic ucs_d, lcs_d, ucs_q, lcs_q;

  always_comb begin
    win = WIN_NONE;
    if (addr_vld) begin
      if      (hit_u) win = WIN_U;
      else if (hit_l) win = WIN_L;
      else if (hit_p) win = WIN_P;
      else if (hit_m) win = WIN_M;
    end
    case (win)
      WIN_U:   begin wait_st = {2'b00, ucfg.ws}; need_rdy = ucfg.rdy; end
      WIN_L:   begin wait_st = {2'b00, lcfg.ws}; need_rdy = lcfg.rdy; end
      WIN_M:   begin wait_st = {2'b00, mcfg.ws}; need_rdy = mcfg.rdy; end
      WIN_P:   begin wait_st = pcs_wait(pcfg.code, pslot > 3'd4); need_rdy = pcfg.rdy; end
      default: begin wait_st = 4'd0; need_rdy = 1'b0; end
    endcase
    ucs_d = (win != WIN_U);
    lcs_d = (win != WIN_L);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ucs_q <= 1'b1;
      lcs_q <= 1'b1;
    end else begin
      ucs_q <= ucs_d;
      lcs_q <= lcs_d;
    end
  end
  assign ucs_n = ucs_q;
  assign lcs_n = lcs_q;

  for (genvar g = 0; g < NMCS; g++) begin : g_mcs
    assign mcs_n[g] = !((win == WIN_M) && (msub == 2'(g)));
  end

  for (genvar g = 0; g < NPCS; g++) begin : g_pcs
    if (g == GAP_SLOT) begin : g_gap
      assign pcs_n[g] = 1'b1;
    end else begin : g_slot
      assign pcs_n[g] = !((win == WIN_P) && (pslot == 3'(g)));
    end
  end
endmodule

// File: rtl/csdec_chk.sv
module csdec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       addr_vld,
  input logic       is_mem,
  input logic       ucs_n,
  input logic       lcs_n,
  input logic [3:0] mcs_n,
  input logic [6:0] pcs_n,
  input logic [3:0] wait_st
);
  AST_FAST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |-> (&mcs_n && &pcs_n)); // R8
  AST_SLOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> (ucs_n && lcs_n)); // R8
  AST_ONE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~mcs_n, ~pcs_n})); // R9
  AST_ONE_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ucs_n && !lcs_n)); // R9
  AST_GAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    pcs_n[4]); // R5
  AST_NARROW_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!pcs_n[6] || !pcs_n[5]) |-> (wait_st <= 4'd3)); // R10
  AST_UCS_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    !ucs_n |-> $past(addr_vld && is_mem)); // R7
endmodule

bind csdec_top csdec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .is_mem(is_mem),
  .ucs_n(ucs_n), .lcs_n(lcs_n), .mcs_n(mcs_n), .pcs_n(pcs_n), .wait_st(wait_st)
);

// File: tb/tb_csdec_top.sv
module tb_csdec_top;
  logic        clk = 0;
  logic        rst_n;
  logic [19:0] addr;
  logic        is_mem, addr_vld, cfg_we;
  logic [2:0]  cfg_sel;
  logic [15:0] cfg_wdata;
  logic        ucs_n, lcs_n, need_rdy;
  logic [3:0]  mcs_n, wait_st;
  logic [6:0]  pcs_n;

  always #2 clk = ~clk;

  csdec_top dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model of configuration
  logic [9:0]  m_ub, m_lb, m_mb;
  logic        m_ue, m_ur, m_le, m_lr, m_me, m_mr;
  logic [1:0]  m_uw, m_lw, m_mw;
  logic [11:0] m_pb;
  logic        m_pio, m_pe, m_pr;
  logic [2:0]  m_pc;
  logic [17:0] prev_exp;   // {rdy, wait[3:0], pcs[6:0], mcs[3:0], lcs, ucs}, active-high

  function automatic logic [3:0] map_w(input logic [2:0] c, input logic narrow);
    logic [3:0] t [8] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd5, 4'd7, 4'd9, 4'd15};
    return narrow ? {2'b00, c[1:0]} : t[c];
  endfunction

  function automatic logic [17:0] expect_of(input logic [19:0] a, input logic mem, input logic v);
    logic [17:0] e = '0;
    logic [11:0] pa, pbb, off;
    logic hu, hl, hm, hp;
    hu = v && mem && m_ue && (a[19:10] >= m_ub);
    hl = v && mem && m_le && (a[19:10] <= m_lb);
    hm = v && mem && m_me && (a[19:15] == m_mb[9:5]);
    pa  = m_pio ? {4'h0, a[15:8]} : a[19:8];
    pbb = m_pio ? {4'h0, m_pb[7:0]} : m_pb;
    off = pa - pbb;
    hp = v && m_pe && (m_pio ? !mem : mem) && off < 12'd7 && off != 12'd4;
    if (hu) begin e[0] = 1; e[16:13] = {2'b0, m_uw}; e[17] = m_ur; end
    else if (hl) begin e[1] = 1; e[16:13] = {2'b0, m_lw}; e[17] = m_lr; end
    else if (hp) begin e[6 + off[2:0]] = 1; e[16:13] = map_w(m_pc, off[2:0] > 3'd4); e[17] = m_pr; end
    else if (hm) begin e[2 + a[14:13]] = 1; e[16:13] = {2'b0, m_mw}; e[17] = m_mr; end
    return e;
  endfunction

  task automatic apply_model(input logic [2:0] s, input logic [15:0] d);
    case (s)
      3'd0: begin m_ub = d[15:6]; m_ue = d[3]; m_ur = d[2]; m_uw = d[1:0]; end
      3'd1: begin m_lb = d[15:6]; m_le = d[3]; m_lr = d[2]; m_lw = d[1:0]; end
      3'd2: begin m_mb = d[15:6]; m_me = d[3]; m_mr = d[2]; m_mw = d[1:0]; end
      3'd3: m_pb = d[11:0];
      3'd4: begin m_pio = d[5]; m_pe = d[4]; m_pr = d[3]; m_pc = d[2:0]; end
      default: ;
    endcase
  endtask

  task automatic step(input logic [19:0] a, input logic mem, input logic v,
                      input logic we, input logic [2:0] s, input logic [15:0] d,
                      input string tag);
    logic [17:0] now, act;
    @(posedge clk); #1;
    addr = a; is_mem = mem; addr_vld = v; cfg_we = we; cfg_sel = s; cfg_wdata = d;
    now = expect_of(a, mem, v);
    @(negedge clk);
    act = {need_rdy, wait_st, ~pcs_n, ~mcs_n, ~lcs_n, ~ucs_n};
    checks++;
    if (act !== {now[17:2], prev_exp[1:0]}) begin
      fails++;
      $display("FAIL %s addr=%h mem=%0b vld=%0b actual=%h expected=%h", tag, a, mem, v,
               act, {now[17:2], prev_exp[1:0]});
    end
    prev_exp = now;
    if (we) apply_model(s, d);
  endtask

  task automatic dec(input logic [19:0] a, input logic mem, input string tag);
    step(a, mem, 1'b1, 1'b0, 3'd0, 16'h0, tag);
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d, input string tag);
    step(20'h0, 1'b1, 1'b0, 1'b1, s, d, tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_ub = 10'h3C0; m_ue = 1; m_ur = 1; m_uw = 3;
    m_lb = 0; m_le = 0; m_lr = 0; m_lw = 0;
    m_mb = 0; m_me = 0; m_mr = 0; m_mw = 0;
    m_pb = 0; m_pio = 0; m_pe = 0; m_pr = 0; m_pc = 0;
    prev_exp = '0;
    addr = 0; is_mem = 1; addr_vld = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);

    step(20'hF0000, 1, 0, 0, 0, 0, "R8 reset idle");
    dec(20'hF0000, 1, "R1 first");
    dec(20'hFFFFF, 1, "R1 last");
    dec(20'hEFFFF, 1, "R1 below");
    dec(20'hF0000, 0, "R6 io cycle no ucs");
    step(20'hF0000, 1, 0, 0, 0, 0, "R8 strobe low");
    wr(3'd0, 16'hE00F, "R2 write");
    dec(20'hE0000, 1, "R2 new first");
    dec(20'hDFFFF, 1, "R2 below");
    dec(20'h00000, 1, "R3 disabled");
    wr(3'd1, 16'h00C9, "R3 write");
    dec(20'h00000, 1, "R3 first");
    dec(20'h00FFF, 1, "R3 last");
    dec(20'h01000, 1, "R3 beyond");
    wr(3'd2, 16'h400A, "R4 write");
    dec(20'h40000, 1, "R4 sub0");
    dec(20'h41FFF, 1, "R4 sub0 end");
    dec(20'h42000, 1, "R4 sub1");
    dec(20'h47FFF, 1, "R4 sub3 end");
    dec(20'h48000, 1, "R4 beyond");
    dec(20'h3FFFF, 1, "R4 below");
    dec(20'h20000, 1, "R5 disabled");
    wr(3'd3, 16'h0200, "R5 base");
    wr(3'd4, 16'h0016, "R5 ctl");
    dec(20'h20000, 1, "R10 slot0 wait9");
    dec(20'h203FF, 1, "R5 slot3");
    dec(20'h20400, 1, "R5 slot4 gap");
    dec(20'h20500, 1, "R10 slot5 narrow");
    dec(20'h206FF, 1, "R5 slot6");
    dec(20'h20700, 1, "R5 beyond");
    dec(20'h1FFFF, 1, "R5 below");
    dec(20'h20000, 0, "R6 mem mode io cycle");
    wr(3'd3, 16'h0012, "R6 base");
    wr(3'd4, 16'h0036, "R6 io ctl");
    dec(20'h01200, 0, "R6 io slot0");
    dec(20'h01200, 1, "R6 mem cycle ignored");
    dec(20'hF1300, 0, "R6 upper bits ignored");
    wr(3'd2, 16'hF008, "R9 mcs under ucs");
    dec(20'hF0000, 1, "R9 priority");
    wr(3'd2, 16'h400A, "R11 restore");
    step(20'h40000, 1, 1, 1, 3'd2, 16'h0000, "R11 same cycle");
    dec(20'h40000, 1, "R11 after");
    step(20'h40000, 1, 1, 1, 3'd6, 16'hFFFF, "R11 bad sel");
    dec(20'h00000, 1, "R7 lag");

    void'($urandom(32'h5EED));
    for (int i = 0; i < 600; i++) begin
      logic [19:0] a;
      int k;
      k = $urandom % 6;
      case (k)
        0: a = {m_ub, 10'h0} - 20'($urandom % 2);
        1: a = {m_lb, 10'h3FF} + 20'($urandom % 2);
        2: a = {m_mb[9:5], 15'h0} + 20'($urandom % 20'h9000) - 20'h800;
        3: a = {m_pb, 8'h00} + 20'($urandom % 20'h900) - 20'h80;
        default: a = 20'($urandom);
      endcase
      if ($urandom % 8 == 0)
        step(a, 1'($urandom), 1'($urandom), 1, 3'($urandom % 6), 16'($urandom), "R9 random cfg");
      else
        step(a, ($urandom % 4) != 0, ($urandom % 8) != 0, 0, 0, 0, "R9 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule